// File: doc/BRIEF.md
# MMC Command Issuer with Card Status Check

This block sends a single command to an MMC card and reports whether it succeeded. A requester hands over a 32-bit argument, a 6-bit command index, a response kind and three check enables through a valid/ready request channel. The block decides at once whether a command may go out. It refuses the request if another command or a data transfer still holds the bus. If the command may go out, the block latches the argument before it pulses the start strobe toward an abstract card port. It then waits for either a completion or a command-timeout event. Line-level signalling and CRC generation sit behind that card port.

The block keeps a status word. Card events set the command bits, and neighbouring data logic sets and clears the transfer bits. When a command finishes, the issuer wipes only the command bits and leaves the transfer bits alone. It keeps the response words and, on request, tests the first word against a card-status error mask. After a command timeout it resets the command line through a set / seen-high / seen-low handshake before it reports the failure. If no event arrives within a bounded number of cycles, it gives up.

The result leaves on a valid/ready channel. The result code stays stable until the requester takes it. The request channel accepts nothing while a result is pending, so the requester stalls the block simply by holding `res_ready` low.

Top module: `mmc_cmd_issuer`

## Requirements
- R1: A request accepted while `cmd_inhibit` or `dat_inhibit` is high produces no `card_start` and yields result code 1 (refused).
- R2: `card_start` is a one-cycle pulse issued only after the argument is latched. `card_arg`, `card_index` and `card_rsp_type` equal the request fields from the start pulse until the result, and `card_arg` does not change across the start edge.
- R3: On completion only the command status bits are cleared: bit 0 complete, bit 1 timeout, bit 2 CRC, bit 3 end bit, bit 4 index. The transfer bits are left unchanged: bit 5 complete, bit 6 timeout, bit 7 CRC, bit 8 end bit.
- R4: A command timeout (status bit 1) drives `cl_rst_req` high until `cl_rst_fb` reads 1, then low. The result, code 4, appears only after `cl_rst_fb` has returned to 0.
- R5: With `req_chk_r1` set, a first response word with any bit set under mask 0xFDFFA080 gives code 3. Without `req_chk_r1`, the same word gives code 0.
- R6: Response kinds are 0 none, 1 48-bit, 2 48-bit with busy, and 3 136-bit. Kind 0 keeps all stored words. Kinds 1 and 2 store only word 0 from `card_rsp[31:0]`. Kind 3 stores four words, lowest word first, word i from `card_rsp[32*i+31:32*i]`.
- R7: A CRC error sets status bit 2 only when `req_chk_crc` was set. An index error sets bit 4 only when `req_chk_idx` was set. An end-bit error always sets bit 3. Any of these three bits set at completion gives code 2.
- R8: With `req_switch` set, the card argument is packed as access in 25:24 (from `req_arg[17:16]`), register index in 23:16 (from `req_arg[15:8]`) and value in 15:8 (from `req_arg[7:0]`). All other argument bits are zero.
- R9: If neither completion nor timeout arrives within WAIT_LIMIT cycles of waiting, the result is code 5 and no line reset is requested.
- R10: `res_valid` holds with a stable `res_code` until `res_ready`. `req_ready` is low whenever a command is in flight or a result is pending.
- R11: After reset, `req_ready`=1 and `res_valid`=0, and `status`, `rsp_words`, `cl_rst_req` and `card_start` are all zero.
- R12: Status bit 9 is the OR of the error bits 1 to 4 and 6 to 8, and it follows transfer errors that are set or cleared outside a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Issuer idle, request taken |
| req_arg | input | 32 | Command argument, or packed switch fields |
| req_index | input | 6 | Command index |
| req_rsp_type | input | 2 | Response kind (0 none, 1 48, 2 48 busy, 3 136) |
| req_chk_idx | input | 1 | Enable index check |
| req_chk_crc | input | 1 | Enable CRC check |
| req_chk_r1 | input | 1 | Enable card-status mask check |
| req_switch | input | 1 | Pack req_arg as a switch argument |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_code | output | 3 | 0 ok, 1 refused, 2 command error, 3 card error, 4 timeout, 5 no event |
| cmd_inhibit | input | 1 | Command line busy |
| dat_inhibit | input | 1 | Data lines busy |
| card_start | output | 1 | One-cycle command start strobe |
| card_arg | output | 32 | Argument to card |
| card_index | output | 6 | Index to card |
| card_rsp_type | output | 2 | Response kind to card |
| card_done | input | 1 | Command complete event |
| card_timeout | input | 1 | Command timeout event |
| card_crc_err | input | 1 | Response CRC bad (with card_done) |
| card_idx_err | input | 1 | Response index bad (with card_done) |
| card_end_err | input | 1 | Response end bit bad (with card_done) |
| card_rsp | input | 128 | Response words |
| cl_rst_req | output | 1 | Command-line reset request |
| cl_rst_fb | input | 1 | Command-line reset read-back |
| xfer_set | input | 4 | Set transfer status bits 5..8 |
| xfer_clr | input | 4 | Clear transfer status bits 5..8 |
| status | output | 10 | Status word |
| rsp_words | output | 128 | Stored response, word 0 lowest |

## Verification
Two kinds of fault are easy to miss. A clear that also hits the transfer bits shows up as a changed bit 5 to 8 or a dropped summary bit in the cycle after completion. The bench therefore loads transfer bits before each command and compares them once the result appears. A handshake that skips a step shows up as `res_valid` rising while `cl_rst_fb` is still high, or as `cl_rst_req` that never falls, and the bench holds the read-back high for several cycles to expose it. Stale latches show up as a wrong argument on the start strobe or as response words that change after a command with no response.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  localparam int CMD_ARG_W = 32;
  localparam int ST_W      = 10;
  localparam int XFER_N    = 4;
  localparam int ST_CC     = 0;
  localparam int ST_CTO    = 1;
  localparam int ST_CCRC   = 2;
  localparam int ST_CEB    = 3;
  localparam int ST_CIE    = 4;
  localparam int ST_XLO    = 5;
  localparam int ST_ERR    = 9;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_48   = 2'd1,
    RSP_48B  = 2'd2,
    RSP_136  = 2'd3
  } rsp_kind_e;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_REFUSED  = 3'd1,
    RC_CMD_ERR  = 3'd2,
    RC_CARD_ERR = 3'd3,
    RC_TIMEOUT  = 3'd4,
    RC_NO_EVENT = 3'd5
  } res_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_EVAL, S_RST_SET, S_RST_CLR, S_DONE
  } iss_state_e;

  function automatic logic [CMD_ARG_W-1:0] switch_pack(input logic [CMD_ARG_W-1:0] a);
    return {6'b0, a[17:16], a[15:8], a[7:0], 8'h00};
  endfunction
endpackage

// File: rtl/mmc_cmd_status.sv
module mmc_cmd_status
  import mmc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_done,
  input  logic              ev_timeout,
  input  logic              ev_crc,
  input  logic              ev_idx,
  input  logic              ev_end,
  input  logic              cmd_clr,
  input  logic [XFER_N-1:0] xfer_set,
  input  logic [XFER_N-1:0] xfer_clr,
  output logic [ST_W-1:0]   stat_o
);
  localparam int CMD_N = 5;

  logic [CMD_N-1:0]  cmd_q, cmd_set;
  logic [XFER_N-1:0] xfer_q;
  logic              err_sum;

  always_comb begin
    cmd_set          = '0;
    cmd_set[ST_CC]   = ev_done;
    cmd_set[ST_CTO]  = ev_timeout;
    cmd_set[ST_CCRC] = ev_crc;
    cmd_set[ST_CEB]  = ev_end;
    cmd_set[ST_CIE]  = ev_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      xfer_q <= '0;
    end else begin
      cmd_q  <= (cmd_q & ~{CMD_N{cmd_clr}}) | cmd_set;
      xfer_q <= (xfer_q & ~xfer_clr) | xfer_set;
    end
  end

  assign err_sum = (|cmd_q[CMD_N-1:1]) | (|xfer_q[XFER_N-1:1]);
  assign stat_o  = {err_sum, xfer_q, cmd_q};

  assert_cmd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !ev_done && !ev_timeout) |=> (stat_o[CMD_N-1:0] == '0));
  assert_xfer_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && xfer_set == '0 && xfer_clr == '0) |=> $stable(stat_o[ST_ERR-1:ST_XLO]));
endmodule

// File: rtl/mmc_cmd_rsp_store.sv
module mmc_cmd_rsp_store
  import mmc_cmd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int RSP_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap,
  input  rsp_kind_e                     kind,
  input  logic [WORD_W*RSP_WORDS-1:0]   rsp_in,
  output logic [WORD_W*RSP_WORDS-1:0]   words_o
);
  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] w_q;
    logic              take;
    if (i == 0) begin : g_first
      assign take = cap && (kind != RSP_NONE);
    end else begin : g_upper
      assign take = cap && (kind == RSP_136);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (take) w_q <= rsp_in[i*WORD_W +: WORD_W];
    end
    assign words_o[i*WORD_W +: WORD_W] = w_q;
  end

  assert_none_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && kind == RSP_NONE) |=> $stable(words_o));
  assert_short_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && (kind == RSP_48 || kind == RSP_48B)) |=> $stable(words_o[WORD_W*RSP_WORDS-1:WORD_W]));
endmodule

// File: rtl/mmc_cmd_wait_timer.sv
module mmc_cmd_wait_timer #(
  parameter int LIMIT = 560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mmc_cmd_issuer.sv
module mmc_cmd_issuer
  import mmc_cmd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RSP_WORDS  = 4,
  parameter int IDX_W      = 6,
  parameter int WAIT_LIMIT = 560,
  parameter logic [WORD_W-1:0] R1_MASK = 32'hFDFFA080
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [CMD_ARG_W-1:0]        req_arg,
  input  logic [IDX_W-1:0]            req_index,
  input  logic [1:0]                  req_rsp_type,
  input  logic                        req_chk_idx,
  input  logic                        req_chk_crc,
  input  logic                        req_chk_r1,
  input  logic                        req_switch,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [2:0]                  res_code,
  input  logic                        cmd_inhibit,
  input  logic                        dat_inhibit,
  output logic                        card_start,
  output logic [CMD_ARG_W-1:0]        card_arg,
  output logic [IDX_W-1:0]            card_index,
  output logic [1:0]                  card_rsp_type,
  input  logic                        card_done,
  input  logic                        card_timeout,
  input  logic                        card_crc_err,
  input  logic                        card_idx_err,
  input  logic                        card_end_err,
  input  logic [WORD_W*RSP_WORDS-1:0] card_rsp,
  output logic                        cl_rst_req,
  input  logic                        cl_rst_fb,
  input  logic [XFER_N-1:0]           xfer_set,
  input  logic [XFER_N-1:0]           xfer_clr,
  output logic [ST_W-1:0]             status,
  output logic [WORD_W*RSP_WORDS-1:0] rsp_words
);
  iss_state_e            state_q, state_d;
  res_code_e             code_q, code_d;
  logic [CMD_ARG_W-1:0]  arg_q;
  logic [IDX_W-1:0]      idx_q;
  rsp_kind_e             kind_q;
  logic                  chk_idx_q, chk_crc_q, chk_r1_q;
  logic                  accept, blocked, timer_expired, cmd_clr, r1_bad, resp_err;

  assign accept  = req_valid && (state_q == S_IDLE);
  assign blocked = cmd_inhibit || dat_inhibit;
  assign cmd_clr = (state_q == S_EVAL);
  assign r1_bad  = |(rsp_words[WORD_W-1:0] & R1_MASK);
  assign resp_err = status[ST_CCRC] | status[ST_CEB] | status[ST_CIE];

  mmc_cmd_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_done    (card_done),
    .ev_timeout (card_timeout),
    .ev_crc     (card_done && card_crc_err && chk_crc_q),
    .ev_idx     (card_done && card_idx_err && chk_idx_q),
    .ev_end     (card_done && card_end_err),
    .cmd_clr    (cmd_clr),
    .xfer_set   (xfer_set),
    .xfer_clr   (xfer_clr),
    .stat_o     (status)
  );

  mmc_cmd_rsp_store #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (card_done),
    .kind    (kind_q),
    .rsp_in  (card_rsp),
    .words_o (rsp_words)
  );

  mmc_cmd_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == S_WAIT),
    .expired (timer_expired)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (blocked) begin
          state_d = S_DONE;
          code_d  = RC_REFUSED;
        end else begin
          state_d = S_ISSUE;
        end
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (status[ST_CC] || status[ST_CTO]) state_d = S_EVAL;
        else if (timer_expired) begin
          state_d = S_DONE;
          code_d  = RC_NO_EVENT;
        end
      end
      S_EVAL: begin
        if (status[ST_CTO]) begin
          state_d = S_RST_SET;
          code_d  = RC_TIMEOUT;
        end else begin
          state_d = S_DONE;
          if (resp_err)               code_d = RC_CMD_ERR;
          else if (chk_r1_q && r1_bad) code_d = RC_CARD_ERR;
          else                         code_d = RC_OK;
        end
      end
      S_RST_SET: if (cl_rst_fb)  state_d = S_RST_CLR;
      S_RST_CLR: if (!cl_rst_fb) state_d = S_DONE;
      S_DONE:    if (res_ready)  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      code_q    <= RC_OK;
      arg_q     <= '0;
      idx_q     <= '0;
      kind_q    <= RSP_NONE;
      chk_idx_q <= 1'b0;
      chk_crc_q <= 1'b0;
      chk_r1_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (accept && !blocked) begin
        arg_q     <= req_switch ? switch_pack(req_arg) : req_arg;
        idx_q     <= req_index;
        kind_q    <= rsp_kind_e'(req_rsp_type);
        chk_idx_q <= req_chk_idx;
        chk_crc_q <= req_chk_crc;
        chk_r1_q  <= req_chk_r1;
      end
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign res_valid     = (state_q == S_DONE);
  assign res_code      = code_q;
  assign card_start    = (state_q == S_ISSUE);
  assign card_arg      = arg_q;
  assign card_index    = idx_q;
  assign card_rsp_type = kind_q;
  assign cl_rst_req    = (state_q == S_RST_SET);

  assert_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && blocked) |=> (res_valid && res_code == RC_REFUSED && !card_start));
  assert_arg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    card_start |=> ($stable(card_arg) && !card_start));
  assert_rst_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cl_rst_req) |-> cl_rst_fb);
  assert_rst_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cl_rst_req |-> !res_valid);
  assert_r1_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == RC_OK && chk_r1_q) |-> ((rsp_words[WORD_W-1:0] & R1_MASK) == '0));
  assert_give_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expired |=> (res_valid && res_code == RC_NO_EVENT && !cl_rst_req));
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code)));
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));
endmodule

// File: tb/mmc_cmd_issuer_tb.sv
module mmc_cmd_issuer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'hFDFFA080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_chk_idx = 0, req_chk_crc = 0, req_chk_r1 = 0, req_switch = 0;
  logic [31:0] req_arg = '0;
  logic [5:0] req_index = '0;
  logic [1:0] req_rsp_type = '0;
  logic res_ready = 0, cmd_inhibit = 0, dat_inhibit = 0;
  logic card_done = 0, card_timeout = 0, card_crc_err = 0, card_idx_err = 0, card_end_err = 0;
  logic [127:0] card_rsp = '0;
  logic cl_rst_fb = 0;
  logic [3:0] xfer_set = '0, xfer_clr = '0;
  logic req_ready, res_valid, card_start, cl_rst_req;
  logic [2:0] res_code;
  logic [31:0] card_arg;
  logic [5:0] card_index;
  logic [1:0] card_rsp_type;
  logic [9:0] status;
  logic [127:0] rsp_words;

  int checks = 0, errors = 0, starts = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_cmd_issuer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_arg(req_arg), .req_index(req_index), .req_rsp_type(req_rsp_type),
    .req_chk_idx(req_chk_idx), .req_chk_crc(req_chk_crc), .req_chk_r1(req_chk_r1),
    .req_switch(req_switch), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .cmd_inhibit(cmd_inhibit), .dat_inhibit(dat_inhibit),
    .card_start(card_start), .card_arg(card_arg), .card_index(card_index),
    .card_rsp_type(card_rsp_type), .card_done(card_done), .card_timeout(card_timeout),
    .card_crc_err(card_crc_err), .card_idx_err(card_idx_err), .card_end_err(card_end_err),
    .card_rsp(card_rsp), .cl_rst_req(cl_rst_req), .cl_rst_fb(cl_rst_fb),
    .xfer_set(xfer_set), .xfer_clr(xfer_clr), .status(status), .rsp_words(rsp_words)
  );

  // per-clock monitor: start pulses counted, handshake exclusivity checked
  always @(posedge clk) if (rst_n && card_start) starts++;
  always @(negedge clk) if (rst_n && req_ready && res_valid) begin
    checks++; errors++;
    $display("FAIL R10 req_ready and res_valid both high actual 1 expected 0");
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 completion, 1 timeout, 2 silent
  task automatic run_cmd(input logic [31:0] arg, input logic [5:0] idx, input logic [1:0] typ,
                         input logic ci, input logic cc, input logic cr, input logic sw,
                         input int kind, input logic [127:0] rsp,
                         input logic e_crc, input logic e_idx, input logic e_end,
                         input int hold,
                         output logic [2:0] code, output logic seen, output logic [31:0] s_arg,
                         output logic [5:0] s_idx, output logic [1:0] s_typ,
                         output logic rst_seen, output logic early);
    seen = 0; rst_seen = 0; early = 0; s_arg = '0; s_idx = '0; s_typ = '0;
    @(negedge clk);
    req_valid = 1; req_arg = arg; req_index = idx; req_rsp_type = typ;
    req_chk_idx = ci; req_chk_crc = cc; req_chk_r1 = cr; req_switch = sw;
    @(negedge clk);
    req_valid = 0; req_arg = '0; req_switch = 0;
    for (int i = 0; i < 10; i++) begin
      if (card_start) begin
        seen = 1; s_arg = card_arg; s_idx = card_index; s_typ = card_rsp_type;
        break;
      end
      if (res_valid) break;
      @(negedge clk);
    end
    if (seen) begin
      repeat (2) @(negedge clk);
      if (kind == 0) begin
        card_done = 1; card_rsp = rsp; card_crc_err = e_crc; card_idx_err = e_idx; card_end_err = e_end;
        @(negedge clk);
        card_done = 0; card_rsp = '0; card_crc_err = 0; card_idx_err = 0; card_end_err = 0;
      end else if (kind == 1) begin
        card_timeout = 1;
        @(negedge clk);
        card_timeout = 0;
        for (int i = 0; i < 20; i++) begin
          if (cl_rst_req) break;
          @(negedge clk);
        end
        if (cl_rst_req) begin
          rst_seen = 1;
          repeat (2) @(negedge clk);
          cl_rst_fb = 1;
          for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cl_rst_req) break;
          end
          if (cl_rst_req) rst_seen = 0;
          repeat (3) begin
            @(negedge clk);
            if (res_valid) early = 1;
          end
          cl_rst_fb = 0;
        end
      end
    end
    for (int i = 0; i < 2000; i++) begin
      if (res_valid) break;
      @(negedge clk);
    end
    code = res_code;
    repeat (hold) begin
      @(negedge clk);
      chk("R10 result held", {res_valid, res_code}, {1'b1, code});
      chk("R10 no request accepted", req_ready, 1'b0);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] code;
    logic seen, rs, early;
    logic [31:0] sa;
    logic [5:0] si;
    logic [1:0] st;
    int s0;
    logic [127:0] keep;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 req_ready", req_ready, 1'b1);
    chk("R11 res_valid", res_valid, 1'b0);
    chk("R11 status", status, '0);
    chk("R11 rsp_words", rsp_words, '0);
    chk("R11 cl_rst_req/card_start", {cl_rst_req, card_start}, 2'b00);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R6 plain 48-bit command with clean status
    run_cmd(32'hCAFE_0123, 6'd13, 2'd1, 1, 1, 1, 0, 0, {96'h0, 32'h0000_0900},
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R2 start seen", seen, 1'b1);
    chk("R2 card_arg", sa, 32'hCAFE_0123);
    chk("R2 index/type", {si, st}, {6'd13, 2'd1});
    chk("R5 clean status code", code, 3'd0);
    chk("R6 48-bit word0", rsp_words, {96'h0, 32'h0000_0900});
    chk("R3 command bits cleared", status[4:0], 5'b0);

    // R3 R12 transfer bits preserved through completion
    @(negedge clk); xfer_set = 4'b0101; @(negedge clk); xfer_set = '0;
    chk("R12 summary follows transfer crc", status[9], 1'b1);
    run_cmd(32'h1, 6'd7, 2'd2, 1, 1, 0, 0, 0, {96'h0, 32'h0000_0700},
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R3 transfer bits kept", status[8:5], 4'b0101);
    chk("R3 command bits cleared, summary kept", {status[9], status[4:0]}, {1'b1, 5'b0});

    // R5 card status mask
    run_cmd(32'h2, 6'd16, 2'd1, 1, 1, 1, 0, 0, {96'h0, 32'h0000_0080},
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R5 masked bit gives card error", code, 3'd3);
    run_cmd(32'h2, 6'd16, 2'd1, 1, 1, 0, 0, 0, {96'h0, 32'h8000_0000},
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R5 unchecked response ok", code, 3'd0);
    run_cmd(32'h2, 6'd16, 2'd1, 1, 1, 1, 0, 0, {96'h0, ~MASK},
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R5 unmasked bits ok", code, 3'd0);

    // R6 136-bit and no-response storage
    run_cmd(32'h0, 6'd9, 2'd3, 0, 1, 0, 0, 0, 128'h4444_4444_3333_3333_2222_2222_1111_1111,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R6 136-bit words lowest first", rsp_words, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
    keep = rsp_words;
    run_cmd(32'h0, 6'd0, 2'd0, 0, 0, 0, 0, 0, 128'hDEAD,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R6 none keeps words", rsp_words, keep);
    chk("R6 none ok", code, 3'd0);
    run_cmd(32'h0, 6'd1, 2'd1, 0, 0, 0, 0, 0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000_0001,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R6 48-bit keeps upper words", rsp_words, {keep[127:32], 32'h0000_0001});

    // R7 check enables
    run_cmd(32'h5, 6'd3, 2'd1, 1, 1, 0, 0, 0, 128'h0,
            1, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R7 crc error checked", code, 3'd2);
    chk("R3 crc bit cleared", status[4:0], 5'b0);
    run_cmd(32'h5, 6'd3, 2'd1, 1, 0, 0, 0, 0, 128'h0,
            1, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R7 crc error ignored", code, 3'd0);
    run_cmd(32'h5, 6'd3, 2'd1, 0, 0, 0, 0, 0, 128'h0,
            0, 1, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R7 index error ignored", code, 3'd0);
    run_cmd(32'h5, 6'd3, 2'd1, 1, 0, 0, 0, 0, 128'h0,
            0, 1, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R7 index error checked", code, 3'd2);
    run_cmd(32'h5, 6'd3, 2'd1, 0, 0, 0, 0, 0, 128'h0,
            0, 0, 1, 0, code, seen, sa, si, st, rs, early);
    chk("R7 end bit always checked", code, 3'd2);

    // R1 refusal
    s0 = starts;
    cmd_inhibit = 1;
    run_cmd(32'h9, 6'd17, 2'd1, 1, 1, 1, 0, 0, 128'h0,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R1 refused with command inhibit", code, 3'd1);
    cmd_inhibit = 0; dat_inhibit = 1;
    run_cmd(32'h9, 6'd24, 2'd1, 1, 1, 1, 0, 0, 128'h0,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R1 refused with data inhibit", code, 3'd1);
    dat_inhibit = 0;
    chk("R1 no start pulse", starts - s0, 0);

    // R4 timeout handshake
    run_cmd(32'h1, 6'd1, 2'd1, 0, 0, 0, 0, 1, 128'h0,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R4 reset request went high then low", rs, 1'b1);
    chk("R4 no result before read-back low", early, 1'b0);
    chk("R4 timeout code", code, 3'd4);
    chk("R3 timeout bit cleared", status[4:0], 5'b0);

    // R12 summary tracks transfer errors outside commands
    @(negedge clk); xfer_clr = 4'b1111; @(negedge clk); xfer_clr = '0;
    chk("R12 summary clear", {status[9], status[8:5]}, 5'b0);
    xfer_set = 4'b1000; @(negedge clk); xfer_set = '0;
    chk("R12 summary on end-bit error", status[9], 1'b1);
    xfer_clr = 4'b1000; @(negedge clk); xfer_clr = '0;

    // R9 silent card
    run_cmd(32'h3, 6'd2, 2'd1, 0, 0, 0, 0, 2, 128'h0,
            0, 0, 0, 0, code, seen, sa, si, st, rs, early);
    chk("R9 no-event code", code, 3'd5);
    chk("R9 no reset request", cl_rst_req, 1'b0);

    // R8 switch packing, R10 held result
    run_cmd(32'hFFFC_0000 | 32'h0003_B901, 6'd6, 2'd2, 1, 1, 1, 1, 0, 128'h0,
            0, 0, 0, 3, code, seen, sa, si, st, rs, early);
    chk("R8 switch argument", sa, {6'b0, 2'b11, 8'hB9, 8'h01, 8'h00});
    chk("R8 switch ok", code, 3'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule